// File: doc/BRIEF.md
# Three-Wire Write-Only Control Register Bank

This block is the serial programming port of a frequency-synthesizer control bank. A host drives three lines: an active-low enable, a serial clock and a serial data line. While the enable line is low, the block shifts one data bit per rising serial-clock edge into a 22-bit shift register, most significant bit first. When the enable line rises, the block decodes the last 22 bits as a 4-bit address followed by an 18-bit data field. It then stores the data in one of sixteen internal registers. A word that is shorter than 22 bits is dropped.

All three serial lines, and a power-down input, are oversampled in the system clock domain through two-flop synchronizers. The system clock must run at least four times faster than the serial clock. Besides the register contents, the block produces several outputs:
- a one-cycle write strobe that carries the address written;
- a select flag naming which of the two RF loops is active, which follows the RF divider register written most recently;
- a one-cycle self-tune request;
- two decoded configuration fields: a reference divide-by-2 enable and an IF output division ratio.

Top module: `tw_reg_bank`

## Requirements
- R1: After reset, all sixteen registers read zero, the RF select output is 0 and the write strobe is low.
- R2: A word of exactly 22 bits, sent MSB first while the enable is low, is committed on the enable's rising edge. Bits 21..18 select the register and bits 17..0 become its contents, visible on register slice [addr*18 +: 18] of the flat register output.
- R3: Extra leading bits before the word are ignored; only the last 22 bits shifted before the commit are used.
- R4: If fewer than 22 bits were shifted since the enable fell, the rising edge changes no register and gives no strobe.
- R5: While the enable is high, activity on the serial clock and data lines changes no register and gives no strobe.
- R6: Each commit gives a write-strobe pulse exactly one system cycle wide, with the write-address output equal to the committed address in that cycle.
- R7: A write to address 3 sets the RF select to 0, and a write to address 4 sets it to 1. Writes to any other address leave it unchanged.
- R8: The self-tune request pulses for one cycle in three cases: after reset release, after the power-down input falls, and after each write to address 3, 4 or 5. Writes to other addresses give no pulse.
- R9: The reference divide-by-2 output equals bit 6 of register 0.
- R10: The IF division output is a 4-bit value equal to 1, 2, 4 or 8 for codes 0, 1, 2 or 3 in bits 1..0 of register 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en_n | input | 1 | Serial enable, active low; rising edge commits |
| ser_clk | input | 1 | Serial bit clock |
| ser_dat | input | 1 | Serial data, MSB first |
| pwr_dn | input | 1 | Power-down request; its release triggers a self-tune request |
| reg_flat_o | output | 288 | All sixteen 18-bit registers, register i at [i*18 +: 18] |
| wr_stb_o | output | 1 | One-cycle pulse per committed write |
| wr_addr_o | output | 4 | Address of the write being strobed |
| rf_sel_o | output | 1 | Active RF loop: 0 after address 3, 1 after address 4 |
| tune_req_o | output | 1 | One-cycle self-tune request |
| ref_div2_o | output | 1 | Reference divide-by-2 enable |
| if_div_o | output | 4 | IF output division ratio (1, 2, 4, 8) |

## Verification
The commit path is tried with several clean 22-bit words: all-ones data at the top address, single-bit data at a low address, and a mixed pattern. Together these separate the address field from the data field and expose bit-order errors. A word preceded by junk ones tells a design that keeps the last 22 bits apart from one that keeps the first 22. A 15-bit burst and a stream of clocks sent while the enable is high separate a correct length and enable check from a design that commits whatever is in the shift register. Writes to addresses 3, 4, 5 and 7 tell the RF-loop and tune rules apart, and all four IF codes are walked.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int WORD_W = 22;
  localparam int DATA_W = 18;
  localparam int ADDR_W = 4;
  localparam int NREG   = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] CFG_ADDR   = 4'd0;
  localparam logic [ADDR_W-1:0] IFDIV_ADDR = 4'd2;
  localparam logic [ADDR_W-1:0] RFA_ADDR   = 4'd3;
  localparam logic [ADDR_W-1:0] RFB_ADDR   = 4'd4;
  localparam logic [ADDR_W-1:0] IFN_ADDR   = 4'd5;
  localparam int REFDIV_BIT = 6;

  // Index of each line in the synchronizer vector
  localparam int L_EN  = 0;
  localparam int L_CLK = 1;
  localparam int L_DAT = 2;
  localparam int L_PD  = 3;
  localparam int NLINE = 4;

  // True when a write to this address programs a new output frequency
  function automatic logic freq_addr(input logic [ADDR_W-1:0] a);
    return (a == RFA_ADDR) || (a == RFB_ADDR) || (a == IFN_ADDR);
  endfunction

  // 2-bit code to division ratio 1/2/4/8
  function automatic logic [3:0] div_ratio(input logic [1:0] code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
      s3_q <= RST_VAL;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/tw_shift.sv
module tw_shift #(
  parameter int WORD_W = 22,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_lvl_i,
  input  logic              en_fall_i,
  input  logic              en_rise_i,
  input  logic              sck_rise_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);
  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full;

  assign full = (cnt_q == CNT_W'(WORD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (en_fall_i || en_rise_i) begin
      cnt_q <= '0;
    end else if (!en_lvl_i && sck_rise_i) begin
      shreg_q <= {shreg_q[WORD_W-2:0], sdi_i};
      if (!full) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_o   = shreg_q;
  assign commit_o = en_rise_i && full;

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_lvl_i |=> $stable(shreg_q));
  // R4
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORD_W));
endmodule

// File: rtl/tw_bank.sv
module tw_bank
  import tw_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  localparam int NR = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  input  logic             pd_fall_i,
  output logic [NR*DW-1:0] regs_o,
  output logic             wr_stb_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic             rf_sel_o,
  output logic             tune_o
);
  logic boot_q;

  for (genvar i = 0; i < NR; i++) begin : g_reg
    logic [DW-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              r_q <= '0;
      else if (commit_i && addr_i == AW'(i))   r_q <= data_i;
    end
    assign regs_o[i*DW +: DW] = r_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      rf_sel_o  <= 1'b0;
      tune_o    <= 1'b0;
      boot_q    <= 1'b1;
    end else begin
      boot_q   <= 1'b0;
      wr_stb_o <= commit_i;
      if (commit_i) wr_addr_o <= addr_i;
      if (commit_i && addr_i == RFA_ADDR) rf_sel_o <= 1'b0;
      if (commit_i && addr_i == RFB_ADDR) rf_sel_o <= 1'b1;
      tune_o <= boot_q || pd_fall_i || (commit_i && freq_addr(addr_i));
    end
  end

  // R6
  stb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);
  // R2
  stb_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> regs_o[wr_addr_o*DW +: DW] == $past(data_i));
  // R7
  sel_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_sel_o != $past(rf_sel_o)) |->
      (wr_stb_o && (wr_addr_o == RFA_ADDR || wr_addr_o == RFB_ADDR)));
  // R8
  tune_on_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_o && freq_addr(wr_addr_o)) |-> tune_o);
endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank
  import tw_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  localparam int NR = 1 << AW,
  localparam int WW = DW + AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_en_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             pwr_dn,
  output logic [NR*DW-1:0] reg_flat_o,
  output logic             wr_stb_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic             rf_sel_o,
  output logic             tune_req_o,
  output logic             ref_div2_o,
  output logic [3:0]       if_div_o
);
  localparam logic [NLINE-1:0] SYNC_RST = NLINE'(1) << L_EN;

  logic [NLINE-1:0] lines, lvl, rise, fall;
  logic [WW-1:0]    word;
  logic             commit;

  assign lines = {pwr_dn, ser_dat, ser_clk, ser_en_n};

  tw_sync #(.W(NLINE), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(lines),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  tw_shift #(.WORD_W(WW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .en_lvl_i(lvl[L_EN]), .en_fall_i(fall[L_EN]), .en_rise_i(rise[L_EN]),
    .sck_rise_i(rise[L_CLK]), .sdi_i(lvl[L_DAT]),
    .word_o(word), .commit_o(commit)
  );

  tw_bank #(.DW(DW), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .commit_i(commit),
    .addr_i(word[WW-1 -: AW]), .data_i(word[DW-1:0]),
    .pd_fall_i(fall[L_PD]),
    .regs_o(reg_flat_o), .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o),
    .rf_sel_o(rf_sel_o), .tune_o(tune_req_o)
  );

  assign ref_div2_o = reg_flat_o[int'(CFG_ADDR)*DW + REFDIV_BIT];
  assign if_div_o   = div_ratio(reg_flat_o[int'(IFDIV_ADDR)*DW +: 2]);
endmodule

// File: tb/tw_reg_bank_bench.sv
module tw_reg_bank_bench;
  logic clk = 0, rst_n = 0;
  logic ser_en_n = 1, ser_clk = 0, ser_dat = 0, pwr_dn = 0;
  logic [287:0] reg_flat;
  logic wr_stb, rf_sel, tune_req, ref_div2;
  logic [3:0] wr_addr, if_div;

  int n_chk = 0, n_err = 0;
  int stb_cnt = 0, tune_cnt = 0, run = 0, max_run = 0;
  logic [3:0] last_addr = 0;
  logic [17:0] exp_reg [16];
  bit done = 0;

  always #10 clk = ~clk;

  tw_reg_bank u_tw_reg_bank (
    .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .pwr_dn(pwr_dn), .reg_flat_o(reg_flat),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .rf_sel_o(rf_sel),
    .tune_req_o(tune_req), .ref_div2_o(ref_div2), .if_div_o(if_div)
  );

  always @(negedge clk) begin
    if (wr_stb) begin stb_cnt++; last_addr = wr_addr; run++; end
    else run = 0;
    if (run > max_run) max_run = run;
    if (tune_req) tune_cnt++;
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_c(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int n, logic [63:0] bits);
    ser_en_n = 0; wait_c(4);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = bits[i]; wait_c(4);
      ser_clk = 1; wait_c(4);
      ser_clk = 0;
    end
    wait_c(4); ser_en_n = 1; wait_c(10);
  endtask

  task automatic write(logic [3:0] a, logic [17:0] d);
    send(22, {42'd0, a, d});
    exp_reg[a] = d;
  endtask

  task automatic chk_regs(string req);
    for (int i = 0; i < 16; i++)
      chk(reg_flat[i*18 +: 18] == exp_reg[i], req, reg_flat[i*18 +: 18], exp_reg[i]);
  endtask

  task automatic t_reset;
    chk_regs("R1");
    chk(rf_sel == 0, "R1 rf_sel", rf_sel, 0);
    chk(wr_stb == 0, "R1 wr_stb", wr_stb, 0);
    chk(tune_cnt == 1, "R8 reset tune", tune_cnt, 1);
  endtask

  task automatic t_basic;
    int s0 = stb_cnt;
    write(4'd7, 18'h2A5C3);
    chk(stb_cnt == s0 + 1, "R6 strobe count", stb_cnt, s0 + 1);
    chk(last_addr == 7, "R6 strobe addr", last_addr, 7);
    write(4'd15, 18'h3FFFF);
    chk(last_addr == 15, "R6 strobe addr", last_addr, 15);
    write(4'd1, 18'h00001);
    chk_regs("R2");
    chk(max_run == 1, "R6 pulse width", max_run, 1);
  endtask

  task automatic t_leading;
    send(30, {34'd0, 8'hFF, 4'd9, 18'h12345});
    exp_reg[9] = 18'h12345;
    chk_regs("R3");
  endtask

  task automatic t_short;
    int s0 = stb_cnt;
    send(15, {49'd0, 15'h7ABC});
    chk(stb_cnt == s0, "R4 no strobe", stb_cnt, s0);
    chk_regs("R4");
  endtask

  task automatic t_idle;
    int s0 = stb_cnt;
    for (int i = 0; i < 25; i++) begin
      ser_dat = i[0]; wait_c(4); ser_clk = 1; wait_c(4); ser_clk = 0;
    end
    wait_c(10);
    chk(stb_cnt == s0, "R5 no strobe", stb_cnt, s0);
    chk_regs("R5");
  endtask

  task automatic t_rf;
    int t0 = tune_cnt;
    write(4'd4, 18'h01234);
    chk(rf_sel == 1, "R7 sel after 4", rf_sel, 1);
    chk(tune_cnt == t0 + 1, "R8 tune after 4", tune_cnt, t0 + 1);
    write(4'd3, 18'h04321);
    chk(rf_sel == 0, "R7 sel after 3", rf_sel, 0);
    write(4'd4, 18'h00055);
    write(4'd7, 18'h00777);
    chk(rf_sel == 1, "R7 sel kept", rf_sel, 1);
    chk(tune_cnt == t0 + 3, "R8 no tune for 7", tune_cnt, t0 + 3);
    write(4'd5, 18'h00500);
    chk(tune_cnt == t0 + 4, "R8 tune after 5", tune_cnt, t0 + 4);
  endtask

  task automatic t_pd;
    int t0 = tune_cnt;
    pwr_dn = 1; wait_c(8);
    chk(tune_cnt == t0, "R8 no tune in pd", tune_cnt, t0);
    pwr_dn = 0; wait_c(8);
    chk(tune_cnt == t0 + 1, "R8 tune on pd release", tune_cnt, t0 + 1);
  endtask

  task automatic t_cfg;
    write(4'd0, 18'h00040);
    chk(ref_div2 == 1, "R9 ref div on", ref_div2, 1);
    write(4'd0, 18'h3FFBF);
    chk(ref_div2 == 0, "R9 ref div off", ref_div2, 0);
    for (int c = 0; c < 4; c++) begin
      write(4'd2, 18'(c));
      chk(if_div == (4'd1 << c), "R10 if ratio", if_div, 4'd1 << c);
    end
    chk_regs("R2");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) exp_reg[i] = '0;
    wait_c(5); rst_n = 1; wait_c(6);
    t_reset;
    t_basic;
    t_leading;
    t_short;
    t_idle;
    t_rf;
    t_pd;
    t_cfg;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule